// File: doc/BRIEF.md
# Event Status and Interrupt Register

This block gathers single-cycle event pulses from a group of receive and transmit channels into one 16-bit sticky status word. Any event on any channel sets the status bit assigned to that event type. A host reads the status word through a small register port, and that read clears the word. A 16-bit mask word, also reached through the port, chooses which status bits may raise an interrupt.

Two active-low, level-sensitive interrupt lines leave the block. The host line is low whenever an enabled status bit is set. The local-bus line follows the host line, but only while the configuration-mode input is high. Otherwise it stays high.

The status bits are assigned as follows. Bit 2 is a receive CRC error, bit 3 a receive abort and bit 4 a receive length violation. Bit 5 is a receive overflow. Bits 6–7 are the receive large-buffer pair and bits 8–9 the receive small-buffer pair. Bits 10–11 are the receive done-queue write pair. Bit 12 is a transmit underflow and bit 13 a transmit pending-queue read. Bits 14–15 are the transmit done-queue write pair. Bits 0 and 1 carry nothing.

Top module: `evt_irq_reg`

## Requirements
- R1: After reset the status word, the mask word and `rd_data` are all 0, and `irq_n` and `lb_irq_n` are 1.
- R2: A pulse on `ev_pulse[b*NCH+c]` for channel c and status bit b in 2..15 sets status bit b after that clock edge. Pulses on several channels of one bit merge into that one bit.
- R3: Status bits 0 and 1 never set. They read as 0 even when their event inputs pulse.
- R4: Read data appears on `rd_data` one cycle after `rd_en`. Address 0 selects the status word and address 1 the mask word. A status read returns the value held before the read and then clears the word.
- R5: An event that arrives in the same cycle as a status read is not lost. Its bit is set after the read, and the value returned by that read does not include it.
- R6: The mask word is written through address 1 with `wr_en` and reads back as written.
- R7: A write to address 0 does not change the status word.
- R8: `irq_n` is 0 exactly when (status AND mask) is nonzero. A mask bit of 1 enables its status bit. The line returns to 1 as soon as no enabled bit remains.
- R9: `lb_irq_n` equals `irq_n` while `cfg_mode` is 1, and is 1 while `cfg_mode` is 0.
- R10: Addresses 2 and 3 read as 0. Writes to them change neither word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_pulse | input | 16*NCH | Event pulses; index b*NCH+c is bit b, channel c |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address: 0 status, 1 mask |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid the cycle after `rd_en` |
| cfg_mode | input | 1 | Enables the local-bus interrupt |
| irq_n | output | 1 | Host interrupt, active low |
| lb_irq_n | output | 1 | Local-bus interrupt, active low |

## Verification
The bench drives every event index, each status bit on each channel, one at a time. Each read is followed by a second read. This separates a wrong bit position or channel merge (the first read) from a missing clear (the second read), and it shows that bits 0 and 1 stay dead.

For each status bit the mask is swept three ways: only that bit enabled, every bit except it enabled, and all bits enabled after a clear. The local-bus line is checked in both modes each time. Together these tell a masking fault apart from a gating fault.

A status read that coincides with a fresh event is checked separately from reads with no event. Two further cases, an all-channels pulse and writes to the status word and to the unmapped addresses, show that merging and write protection are kept apart.

// File: rtl/evt_irq_reg.sv
module evt_irq_reg #(
  parameter int NCH = 4,
  parameter int AW  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [16*NCH-1:0] ev_pulse,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  input  logic              cfg_mode,
  output logic              irq_n,
  output logic              lb_irq_n
);
  localparam logic [15:0]   LIVE_BITS = 16'hFFFC;
  localparam logic [AW-1:0] A_STAT    = AW'(0);
  localparam logic [AW-1:0] A_MASK    = AW'(1);

  logic [15:0] status, mask, ev_any_raw, ev_any;
  logic        stat_rd, mask_wr, pend;

  for (genvar b = 0; b < 16; b++) begin : g_merge
    assign ev_any_raw[b] = |ev_pulse[b*NCH +: NCH];
  end
  assign ev_any  = ev_any_raw & LIVE_BITS;

  assign stat_rd = rd_en && addr == A_STAT;
  assign mask_wr = wr_en && addr == A_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (stat_rd ? 16'h0 : status) | ev_any;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask <= '0;
    else if (mask_wr) mask <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) begin
      case (addr)
        A_STAT:  rd_data <= status;
        A_MASK:  rd_data <= mask;
        default: rd_data <= '0;
      endcase
    end
  end

  assign pend     = |(status & mask);
  assign irq_n    = ~pend;
  assign lb_irq_n = ~(pend & cfg_mode);

  AST_DEAD_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    status[1:0] == 2'b00); // R3
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_any != 0 |=> (status & $past(ev_any)) == $past(ev_any)); // R2
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && ev_any == 0 |=> status == 0); // R4
  AST_RACE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && ev_any != 0 |=> status == $past(ev_any)); // R5
  AST_STATUS_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !rd_en && ev_any == 0 |=> status == $past(status)); // R7
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask)); // R6
  AST_LB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |-> lb_irq_n); // R9
  AST_LB_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |-> lb_irq_n == irq_n); // R9
endmodule

// File: tb/tb_evt_irq_reg.sv
module tb_evt_irq_reg;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int AW  = 2;

  logic clk = 0, rst_n = 0, rd_en = 0, wr_en = 0, cfg_mode = 0;
  logic [16*NCH-1:0] ev_pulse = '0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic irq_n, lb_irq_n;
  int checks = 0, fails = 0;

  evt_irq_reg #(.NCH(NCH), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .cfg_mode(cfg_mode),
    .irq_n(irq_n), .lb_irq_n(lb_irq_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pulse(input int b, input int c);
    ev_pulse[b*NCH+c] = 1'b1; step(); ev_pulse = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
    rd_en = 1; addr = a; step(); rd_en = 0; d = rd_data;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    wr_en = 1; addr = a; wr_data = d; step(); wr_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    step(); step(); rst_n = 1; #1;
    // R1 reset state
    chk("R1 rd_data", rd_data, 16'h0);
    chk("R1 irq_n", {15'h0, irq_n}, 16'h1);
    chk("R1 lb_irq_n", {15'h0, lb_irq_n}, 16'h1);
    rd(0, d); chk("R1 status", d, 16'h0);
    rd(1, d); chk("R1 mask", d, 16'h0);

    // R2 R3 R4: every bit on every channel
    for (int b = 0; b < 16; b++)
      for (int c = 0; c < NCH; c++) begin
        pulse(b, c);
        rd(0, d);
        chk(b < 2 ? "R3 dead bit" : "R2 set", d, b < 2 ? 16'h0 : 16'(1) << b);
        rd(0, d); chk("R4 cleared", d, 16'h0);
      end

    // R2 all channels, all bits at once
    ev_pulse = '1; step(); ev_pulse = '0;
    rd(0, d); chk("R2 merge all", d, 16'hFFFC);

    // R6 mask read/write
    wr(1, 16'hA5C3); rd(1, d); chk("R6 mask rw", d, 16'hA5C3);
    wr(1, 16'h5A3C); rd(1, d); chk("R6 mask rw2", d, 16'h5A3C);

    // R8 R9 mask sweep
    for (int b = 2; b < 16; b++) begin
      wr(1, 16'(1) << b);
      pulse(b, b % NCH);
      cfg_mode = 0; #1;
      chk("R8 enabled irq", {15'h0, irq_n}, 16'h0);
      chk("R9 lb off", {15'h0, lb_irq_n}, 16'h1);
      cfg_mode = 1; #1;
      chk("R9 lb on", {15'h0, lb_irq_n}, 16'h0);
      wr(1, ~(16'(1) << b)); #1;
      chk("R8 masked irq", {15'h0, irq_n}, 16'h1);
      chk("R9 lb masked", {15'h0, lb_irq_n}, 16'h1);
      wr(1, 16'hFFFF);
      chk("R8 all enabled", {15'h0, irq_n}, 16'h0);
      rd(0, d);
      chk("R8 level release", {15'h0, irq_n}, 16'h1);
      chk("R9 lb release", {15'h0, lb_irq_n}, 16'h1);
      cfg_mode = 0;
    end

    // R5 event during status read
    pulse(7, 1);
    ev_pulse[5*NCH+2] = 1'b1; rd_en = 1; addr = 0; step();
    rd_en = 0; ev_pulse = '0; d = rd_data;
    chk("R5 read value", d, 16'h0080);
    rd(0, d); chk("R5 kept", d, 16'h0020);

    // R7 status write ignored
    pulse(9, 3);
    wr(0, 16'hFFFF); wr(0, 16'h0000);
    rd(0, d); chk("R7 status no write", d, 16'h0200);

    // R10 unmapped addresses
    wr(1, 16'h1234);
    pulse(12, 0);
    wr(2, 16'hFFFF); wr(3, 16'h0000);
    rd(2, d); chk("R10 addr2 zero", d, 16'h0);
    rd(3, d); chk("R10 addr3 zero", d, 16'h0);
    rd(1, d); chk("R10 mask intact", d, 16'h1234);
    rd(0, d); chk("R10 status intact", d, 16'h1000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule